// File: doc/BRIEF.md
# Five-Level Level-Shifted PWM Gate Generator

This block turns a signed control word into the six gate signals of a single-phase, five-level switched-capacitor inverter. The output stage can produce −2, −1, 0, +1 and +2 times the input voltage. The block reaches these levels through six switching states, two of which both give zero volts. An internal up/down counter produces a symmetric triangular carrier. The counter value serves as the lower carrier of a half-cycle, and the same value offset by one carrier amplitude serves as the upper carrier. The magnitude of the control word is compared against both carriers to pick an inner band, an outer band or zero. The sign of the word picks the positive or the negative half, which gives one of the six states.

Each state maps to a fixed pattern of three high-side gate demands:
- one polarity switch, which changes only at line rate;
- two high-frequency switches.

Each high-side gate is paired with a complementary low-side gate. A dead-band unit ensures that both gates of a pair are low for a programmable number of clocks before either of them rises.

The control word is captured once per carrier period, at the peak of the triangle. This avoids more than one transition per switching period. After a synchronous reset, all gates stay low until the state captured at the first peak takes effect. The carrier amplitude in control-word units equals the parameter `HALF_CNT`, which is also the number of clocks in one up ramp. The default of 853 gives about 58.6 kHz with a 100 MHz clock.

Top module: `ml5_lspwm`

## Requirements
- R1: After reset is released, all six gates stay low on the clock edges 1 through `HALF_CNT`+1. The captured state can first drive the gates on the edge after that.
- R2: The control word is captured only when the carrier counter is at its peak value `HALF_CNT`. Any change of the input between two peaks has no effect on the gates.
- R3: With a non-negative captured word W, the state is selected as follows, for carrier counter c:
  - W > `HALF_CNT`+c selects +2 (S3..S8 = 1,0,0,1,0,1);
  - otherwise W > c selects +1 (1,0,1,0,0,1);
  - otherwise the state is positive zero (1,0,0,1,1,0).
  Gates follow the demand one clock later, subject to R6.
- R4: With a negative captured word of magnitude M, the same comparisons with M select:
  - −2 (S3..S8 = 0,1,1,0,1,0);
  - −1 (0,1,0,1,1,0);
  - negative zero (0,1,1,0,0,1).
- R5: A word of zero selects positive zero. A magnitude above 2·`HALF_CNT` holds the ±2 pattern for the whole carrier period, and this includes the most negative word.
- R6: Within a pair, the two gates are never high together. Before a gate rises, both gates of the pair have been low for max(D,1) clocks, where D is `dead_cyc`. A pair whose demand is unchanged keeps its gate.
- R7: The polarity pair (S3,S4) follows the sign of the captured word, so it can change only after a peak capture.
- R8: The carrier counter steps 0 up to `HALF_CNT` and back to 0, with a period of 2·`HALF_CNT` clocks. For an inner-band magnitude m ≥ 1 and D ≥ 1, the high-frequency high gate is high for 2m−1−D clocks per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | CW | Signed control word, two's complement |
| dead_cyc | input | DT_W | Dead time per complementary pair, in clocks |
| pol_pos_g | output | 1 | Polarity switch high side (S3) |
| pol_neg_g | output | 1 | Polarity switch low side (S4) |
| sw_a_hi_g | output | 1 | First PWM switch high side (S5) |
| sw_a_lo_g | output | 1 | First PWM switch low side (S6) |
| sw_b_hi_g | output | 1 | Second PWM switch high side (S7) |
| sw_b_lo_g | output | 1 | Second PWM switch low side (S8) |

## Verification
The bench builds the block with `HALF_CNT` = 8, a 4-bit dead time and a 16-bit control word. A carrier period is then 16 clocks, and control values within ±20 sweep the zero, inner, outer and saturated regions many times within a few thousand cycles. The short carrier keeps peak captures frequent, so the following cases all recur often:
- sign changes of the polarity switch;
- dead times from 0 to 3 that are comparable to the pulse widths;
- the clamp of a zero dead time to one clock.

// File: rtl/ml5_pkg.sv
`timescale 1ns/1ps
package ml5_pkg;

   typedef enum logic [2:0] {
      LV_P0, LV_P1, LV_P2, LV_N0, LV_N1, LV_N2
   } lvl_e;

   // high-side demands of the three complementary pairs
   typedef struct packed {
      logic pol;    // S3
      logic arm_a;  // S5
      logic arm_b;  // S7
   } leg_dem_t;

   function automatic leg_dem_t lvl_pattern(lvl_e s);
      leg_dem_t d;
      case (s)
         LV_P0:   d = '{pol: 1'b1, arm_a: 1'b0, arm_b: 1'b1};
         LV_P1:   d = '{pol: 1'b1, arm_a: 1'b1, arm_b: 1'b0};
         LV_P2:   d = '{pol: 1'b1, arm_a: 1'b0, arm_b: 1'b0};
         LV_N0:   d = '{pol: 1'b0, arm_a: 1'b1, arm_b: 1'b0};
         LV_N1:   d = '{pol: 1'b0, arm_a: 1'b0, arm_b: 1'b1};
         LV_N2:   d = '{pol: 1'b0, arm_a: 1'b1, arm_b: 1'b1};
         default: d = '{pol: 1'b1, arm_a: 1'b0, arm_b: 1'b1};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/ml5_carrier.sv
`timescale 1ns/1ps
module ml5_carrier #(
   parameter int HALF_CNT = 853,
   parameter int CNT_W    = 10
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             apex
);
   localparam logic [CNT_W-1:0] TOP    = CNT_W'(HALF_CNT);
   localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(HALF_CNT - 1);

   logic up;

   assign apex = (cnt == TOP);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (up) begin
         if (cnt == TOP) begin
            up  <= 1'b0;
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= TOP);  // R8
   AST_APEX_TURNS:    assert property (@(posedge clk) disable iff (rst) apex |=> (cnt == TOP_M1));  // R8

endmodule

// File: rtl/ml5_band_select.sv
`timescale 1ns/1ps
module ml5_band_select
   import ml5_pkg::*;
#(
   parameter int CW       = 16,
   parameter int CNT_W    = 10,
   parameter int HALF_CNT = 853
) (
   input  logic [CW-1:0]    ctl,
   input  logic [CNT_W-1:0] cnt,
   output lvl_e             lvl,
   output leg_dem_t         dem
);
   localparam int MW = ((CW > CNT_W) ? CW : CNT_W) + 2;

   logic          neg;
   logic [CW-1:0] mag_raw;
   logic [MW-1:0] mag, lo_car, hi_car;

   assign neg     = ctl[CW-1];
   assign mag_raw = neg ? (~ctl + 1'b1) : ctl;
   assign mag     = MW'(mag_raw);
   assign lo_car  = MW'(cnt);
   assign hi_car  = MW'(cnt) + MW'(HALF_CNT);

   always_comb begin
      if (mag > hi_car)      lvl = neg ? LV_N2 : LV_P2;
      else if (mag > lo_car) lvl = neg ? LV_N1 : LV_P1;
      else                   lvl = neg ? LV_N0 : LV_P0;
      dem = lvl_pattern(lvl);
   end

endmodule

// File: rtl/ml5_deadband.sv
`timescale 1ns/1ps
module ml5_deadband #(
   parameter int DT_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic            want_hi,
   input  logic [DT_W-1:0] dead,
   output logic            hi,
   output logic            lo
);
   logic [DT_W-1:0] tmr;  // clocks both gates have been low

   always_ff @(posedge clk) begin
      if (rst) begin
         hi  <= 1'b0;
         lo  <= 1'b0;
         tmr <= '0;
      end else if (!en) begin
         hi <= 1'b0;
         lo <= 1'b0;
         if (tmr != '1) tmr <= tmr + 1'b1;
      end else if (want_hi ? hi : lo) begin
         hi <= hi;
         lo <= lo;
      end else if (hi || lo) begin
         hi  <= 1'b0;
         lo  <= 1'b0;
         tmr <= DT_W'(1);
      end else if (tmr >= dead) begin
         hi <= want_hi;
         lo <= !want_hi;
      end else begin
         tmr <= tmr + 1'b1;
      end
   end

   AST_NO_SHOOT:     assert property (@(posedge clk) disable iff (rst) !(hi && lo));  // R6
   AST_HI_RISE_GAP:  assert property (@(posedge clk) disable iff (rst) $rose(hi) |-> !$past(lo));  // R6
   AST_LO_RISE_GAP:  assert property (@(posedge clk) disable iff (rst) $rose(lo) |-> !$past(hi));  // R6

endmodule

// File: rtl/ml5_lspwm.sv
`timescale 1ns/1ps
module ml5_lspwm
   import ml5_pkg::*;
#(
   parameter int CW       = 16,
   parameter int HALF_CNT = 853,
   parameter int DT_W     = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [CW-1:0]   ctrl_word,
   input  logic [DT_W-1:0] dead_cyc,
   output logic            pol_pos_g,
   output logic            pol_neg_g,
   output logic            sw_a_hi_g,
   output logic            sw_a_lo_g,
   output logic            sw_b_hi_g,
   output logic            sw_b_lo_g
);
   localparam int CNT_W = $clog2(HALF_CNT + 1);
   localparam int NPAIR = 3;

   if (CW < 4) begin : g_bad_cw
      $error("ml5_lspwm: CW must be at least 4");
   end
   if (HALF_CNT < 2) begin : g_bad_half
      $error("ml5_lspwm: HALF_CNT must be at least 2");
   end
   if (2 * HALF_CNT >= (2 ** (CW - 1))) begin : g_bad_range
      $error("ml5_lspwm: outer band not reachable with CW");
   end
   if (DT_W < 1) begin : g_bad_dt
      $error("ml5_lspwm: DT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             apex;
   logic [CW-1:0]    ctl_q;
   logic             armed;
   lvl_e             lvl;
   leg_dem_t         dem;
   logic [NPAIR-1:0] want, hi_v, lo_v;

   ml5_carrier #(.HALF_CNT(HALF_CNT), .CNT_W(CNT_W)) u_car (
      .clk(clk), .rst(rst), .cnt(cnt), .apex(apex)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= '0;
         armed <= 1'b0;
      end else if (apex) begin
         ctl_q <= ctrl_word;
         armed <= 1'b1;
      end
   end

   ml5_band_select #(.CW(CW), .CNT_W(CNT_W), .HALF_CNT(HALF_CNT)) u_sel (
      .ctl(ctl_q), .cnt(cnt), .lvl(lvl), .dem(dem)
   );

   assign want = {dem.pol, dem.arm_a, dem.arm_b};

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      ml5_deadband #(.DT_W(DT_W)) u_db (
         .clk(clk), .rst(rst), .en(armed), .want_hi(want[i]),
         .dead(dead_cyc), .hi(hi_v[i]), .lo(lo_v[i])
      );
   end

   assign pol_pos_g = hi_v[2];
   assign pol_neg_g = lo_v[2];
   assign sw_a_hi_g = hi_v[1];
   assign sw_a_lo_g = lo_v[1];
   assign sw_b_hi_g = hi_v[0];
   assign sw_b_lo_g = lo_v[0];

   AST_QUIET_BEFORE_APEX: assert property (@(posedge clk) disable iff (rst) !armed |-> ((hi_v | lo_v) == '0));  // R1
   AST_CTL_HELD:          assert property (@(posedge clk) disable iff (rst) !apex |=> $stable(ctl_q));  // R2
   AST_POL_LINE_RATE:     assert property (@(posedge clk) disable iff (rst) !$past(apex) |-> $stable(dem.pol));  // R7
   AST_ZERO_IS_P0:        assert property (@(posedge clk) disable iff (rst) (ctl_q == '0) |-> (lvl == LV_P0));  // R5

endmodule

// File: tb/ml5_lspwm_test.sv
`timescale 1ns/1ps
module ml5_lspwm_test;
   localparam int CW   = 16;
   localparam int HALF = 8;
   localparam int DTW  = 4;
   localparam int PER  = 2 * HALF;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [CW-1:0]  ctrl = '0;
   logic [DTW-1:0] dead = DTW'(2);
   logic g3, g4, g5, g6, g7, g8;

   ml5_lspwm #(.CW(CW), .HALF_CNT(HALF), .DT_W(DTW)) uut (
      .clk(clk), .rst(rst), .ctrl_word(ctrl), .dead_cyc(dead),
      .pol_pos_g(g3), .pol_neg_g(g4), .sw_a_hi_g(g5),
      .sw_a_lo_g(g6), .sw_b_hi_g(g7), .sw_b_lo_g(g8)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   // reference model, built from the requirements
   int m_cnt;
   bit m_up;
   int m_ctl;
   bit m_arm;
   bit m_hi [3];
   bit m_lo [3];
   int m_t  [3];

   // returns {S3,S5,S7}
   function automatic bit [2:0] lvl_bits(int c, int cnt);
      int mag;
      mag = (c < 0) ? -c : c;
      if (c >= 0) begin
         if (mag > HALF + cnt) return 3'b100;
         else if (mag > cnt)   return 3'b110;
         else                  return 3'b101;
      end else begin
         if (mag > HALF + cnt) return 3'b011;
         else if (mag > cnt)   return 3'b001;
         else                  return 3'b010;
      end
   endfunction

   always @(posedge clk) begin
      bit [2:0] w;
      if (rst) begin
         m_cnt = 0; m_up = 1'b1; m_ctl = 0; m_arm = 1'b0;
         for (int p = 0; p < 3; p++) begin
            m_hi[p] = 1'b0; m_lo[p] = 1'b0; m_t[p] = 0;
         end
      end else begin
         w = lvl_bits(m_ctl, m_cnt);
         for (int p = 0; p < 3; p++) begin
            bit wh;
            wh = w[2-p];
            if (!m_arm) begin
               m_hi[p] = 1'b0; m_lo[p] = 1'b0;
               if (m_t[p] < 15) m_t[p] = m_t[p] + 1;
            end else if (wh ? m_hi[p] : m_lo[p]) begin
               m_hi[p] = m_hi[p];
            end else if (m_hi[p] || m_lo[p]) begin
               m_hi[p] = 1'b0; m_lo[p] = 1'b0; m_t[p] = 1;
            end else if (m_t[p] >= int'(dead)) begin
               m_hi[p] = wh; m_lo[p] = !wh;
            end else begin
               m_t[p] = m_t[p] + 1;
            end
         end
         if (m_cnt == HALF) begin
            m_ctl = int'($signed(ctrl));
            m_arm = 1'b1;
         end
         if (m_up) begin
            if (m_cnt == HALF) begin m_up = 1'b0; m_cnt = m_cnt - 1; end
            else m_cnt = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin m_up = 1'b1; m_cnt = m_cnt + 1; end
            else m_cnt = m_cnt - 1;
         end
      end
   end

   task automatic chk(string req, bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clock, gates compared with the model
   task automatic tick(string tag);
      string t;
      @(negedge clk);
      t = (tag != "") ? tag : ((m_ctl >= 0) ? "R3" : "R4");
      chk("R7", {g3, g4} == {m_hi[0], m_lo[0]}, "polarity pair", int'({g3, g4}), int'({m_hi[0], m_lo[0]}));
      chk(t, {g5, g6} == {m_hi[1], m_lo[1]}, "pair A", int'({g5, g6}), int'({m_hi[1], m_lo[1]}));
      chk(t, {g7, g8} == {m_hi[2], m_lo[2]}, "pair B", int'({g7, g8}), int'({m_hi[2], m_lo[2]}));
      chk("R6", !(g3 && g4) && !(g5 && g6) && !(g7 && g8), "shoot-through",
          int'({g3, g4, g5, g6, g7, g8}), 0);
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL R1 watchdog actual=hang expected=finish");
         finish_run();
      end
   end

   initial begin
      int cnt_hi;
      int gap;
      bit gap_ok;
      bit p5, p6;
      int v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: quiet until the first peak capture takes effect
      for (int i = 0; i < HALF + 1; i++) begin
         @(negedge clk);
         chk("R1", {g3, g4, g5, g6, g7, g8} == 6'b0, "gates before first apex",
             int'({g3, g4, g5, g6, g7, g8}), 0);
      end

      // R5: zero selects positive zero state
      repeat (2 * PER) tick("R5");
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         chk("R5", {g3, g4, g5, g6, g7, g8} == 6'b100110, "zero word state",
             int'({g3, g4, g5, g6, g7, g8}), 6'b100110);
      end

      // R8: inner-band pulse width, positive and negative
      dead = 4'd2;
      ctrl = 16'd4;
      repeat (3 * PER) tick("R8");
      cnt_hi = 0;
      for (int i = 0; i < PER; i++) begin tick("R8"); cnt_hi += int'(g5); end
      chk("R8", cnt_hi == 5, "S5 high clocks per period", cnt_hi, 5);
      ctrl = -16'sd4;
      repeat (3 * PER) tick("R8");
      cnt_hi = 0;
      for (int i = 0; i < PER; i++) begin tick("R8"); cnt_hi += int'(g7); end
      chk("R8", cnt_hi == 5, "S7 high clocks per period", cnt_hi, 5);

      // R5: saturation positive and most negative
      ctrl = 16'd20;
      repeat (3 * PER) tick("R5");
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         chk("R5", {g3, g4, g5, g6, g7, g8} == 6'b100101, "positive saturation",
             int'({g3, g4, g5, g6, g7, g8}), 6'b100101);
      end
      ctrl = 16'h8000;
      repeat (3 * PER) tick("R5");
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         chk("R5", {g3, g4, g5, g6, g7, g8} == 6'b011010, "negative saturation",
             int'({g3, g4, g5, g6, g7, g8}), 6'b011010);
      end

      // R2: change between peaks is ignored
      while (!(m_cnt == HALF - 2 && !m_up)) tick("R2");
      ctrl = 16'd20;
      for (int i = 0; i < HALF; i++) begin
         @(negedge clk);
         chk("R2", {g3, g4, g5, g6, g7, g8} == 6'b011010, "input change between peaks",
             int'({g3, g4, g5, g6, g7, g8}), 6'b011010);
      end
      ctrl = 16'h8000;
      repeat (2 * PER) tick("R2");

      // R6: dead time gap of exactly D clocks on pair A
      dead = 4'd3;
      ctrl = 16'd5;
      repeat (3 * PER) tick("R6");
      gap = 0; gap_ok = 1'b0; p5 = g5; p6 = g6;
      for (int i = 0; i < 3 * PER; i++) begin
         tick("R6");
         if ((g5 && !p5) || (g6 && !p6)) begin
            if (gap_ok) chk("R6", gap == 3, "dead gap clocks", gap, 3);
            gap_ok = 1'b0;
         end
         if (!g5 && !g6) begin
            if ((p5 || p6)) begin gap = 1; gap_ok = 1'b1; end
            else gap++;
         end
         p5 = g5; p6 = g6;
      end

      // R3 / R4 / R7: random words, random dead time
      for (int s = 0; s < 160; s++) begin
         v = int'($urandom_range(40)) - 20;
         if (s % 23 == 5) v = 0;
         if (s % 31 == 7) v = -32768;
         ctrl = 16'(v);
         if (s % 10 == 0) dead = DTW'($urandom_range(3));
         repeat (int'($urandom_range(40)) + 1) tick("");
      end

      done = 1'b1;
      finish_run();
   end
endmodule